// File: doc/BRIEF.md
# Receive Link Fault and Lock-Source Monitor

This block supervises a single serial receive channel. It makes two decisions. The first is whether the receive clock-recovery loop should follow the local reference clock or lock onto the incoming data. The second is whether the link is faulted, which it reports on an active-low output.

The frequency-range checker, the amplitude detector, the channel enable and the reference-clock presence reach the block as plain status flags. A transition-density checker inside the block watches the recovered bit stream. That stream arrives one bit per clock and is qualified by a valid strobe. If the stream stays at one level for too long, the checker raises a density fault. The fault clears on the next change of level.

A use-local-clock control can pin the loop to the reference clock. A detector-enable control selects how the lock source is chosen. In one mode all three link-quality checks take part. In the other mode only the range check does.

Top module: `rx_link_supervisor`

## Requirements
- R1: After the synchronous active-high reset, `lockToRef` is 1 and `linkFaultN` is 0. The density fault stays set through reset, and it stays set afterwards until the first level change in the valid bit stream, even when every status flag is good.
- R2: The density fault sets on the RUN_LIMIT-th (default 60) consecutive valid bit that equals its predecessor. One bit fewer leaves it clear. The run count saturates at RUN_LIMIT, so any longer run keeps the fault set.
- R3: A valid bit that differs from the previous valid bit clears the density fault and restarts the run count at zero. The first valid bit after reset has no predecessor, so it neither clears nor counts.
- R4: Cycles with `bitValid` low neither advance nor restart the run count, whatever `bitIn` carries.
- R5: With `detEnable` = 1 and `useLocalClk` = 1, `lockToRef` is 1 while the range flag, the amplitude flag or the density check is failing. It returns to 0 only once all three are good.
- R6: With `detEnable` = 0 and `useLocalClk` = 1, `lockToRef` equals the inverse of `rangeOk`. Amplitude and density results do not affect it.
- R7: With `useLocalClk` = 0, `lockToRef` is 1 and `linkFaultN` is 0, regardless of every other input.
- R8: `linkFaultN` is 0 exactly when at least one of six causes holds: `rangeOk` = 0, `levelOk` = 0, density fault set, `chanEnable` = 0, `useLocalClk` = 0, or `refClkPresent` = 0. This holds in both detector modes.
- R9: Both outputs are registered. They change at the first rising clock edge that samples the changed flag or the valid bit that caused the change, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| bitIn | input | 1 | Recovered serial bit |
| bitValid | input | 1 | Qualifies `bitIn` for this cycle |
| rangeOk | input | 1 | Data rate inside the expected range |
| levelOk | input | 1 | Input amplitude above the threshold |
| chanEnable | input | 1 | Receive channel enabled |
| refClkPresent | input | 1 | Reference clock detected |
| useLocalClk | input | 1 | 1 allows data tracking, 0 forces the reference clock |
| detEnable | input | 1 | 1 selects gating by all detectors, 0 selects gating by range only |
| lockToRef | output | 1 | 1 selects the reference clock, 0 selects data tracking |
| linkFaultN | output | 1 | Link fault, active low |

## Verification
A level change in the bit stream and a change of a status flag can land on the same clock edge. One edge can then clear the density fault while the amplitude flag drops. The bench provokes this by presenting a transitioning valid bit in the same cycle that it pulls `levelOk` low while the density fault is set. It expects the outputs at that edge to stay at the reference clock with the fault asserted. When the amplitude flag alone is restored on the next edge, the outputs must switch to data tracking with no fault. That proves the density fault had cleared on the shared edge.

// File: rtl/rxsup_pkg.sv
package rxsup_pkg;

  // Per-bit events reported by the run-length datapath to the decision logic
  typedef struct packed {
    logic sawEdge;   // valid bit differs from the previous valid bit
    logic hitLimit;  // valid bit completes a run of RUN_LIMIT equal bits
  } runStrobe_t;

  // The six independent reasons for a link fault
  typedef struct packed {
    logic rateBad;
    logic levelBad;
    logic densityBad;
    logic chanOff;
    logic localForced;
    logic refMissing;
  } faultCause_t;

endpackage

// File: rtl/rxsup_run_counter.sv
module rxsup_run_counter
  import rxsup_pkg::*;
#(
  parameter int RUN_LIMIT = 60
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bitIn,
  input  logic       bitValid,
  output runStrobe_t strobe
);

  localparam int CNT_W = $clog2(RUN_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_LIMIT - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(RUN_LIMIT);

  logic             prevBit;
  logic             havePrev;
  logic [CNT_W-1:0] runCnt;
  logic             sameBit;

  assign sameBit         = bitValid && havePrev && (bitIn == prevBit);
  assign strobe.sawEdge  = bitValid && havePrev && (bitIn != prevBit);
  assign strobe.hitLimit = sameBit && (runCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      prevBit  <= 1'b0;
      havePrev <= 1'b0;
      runCnt   <= '0;
    end else if (bitValid) begin
      prevBit  <= bitIn;
      havePrev <= 1'b1;
      if (strobe.sawEdge) begin
        runCnt <= '0;
      end else if (sameBit && (runCnt != CNT_FULL)) begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (rst)
    runCnt <= CNT_FULL);                                          // R2
  AST_EDGE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    strobe.sawEdge |=> (runCnt == '0));                           // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !bitValid |=> $stable(runCnt));                               // R4

endmodule

// File: rtl/rxsup_decide.sv
module rxsup_decide
  import rxsup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  runStrobe_t strobe,
  input  logic       rangeOk,
  input  logic       levelOk,
  input  logic       chanEnable,
  input  logic       refClkPresent,
  input  logic       useLocalClk,
  input  logic       detEnable,
  output logic       lockToRef,
  output logic       linkFaultN
);

  logic        densFault;
  logic        densNext;
  logic        detectorBad;
  faultCause_t cause;

  // Density state: a level change wins over a completed run (they are exclusive anyway)
  always_comb begin
    densNext = densFault;
    if (strobe.sawEdge)       densNext = 1'b0;
    else if (strobe.hitLimit) densNext = 1'b1;
  end

  always_comb begin
    cause.rateBad     = !rangeOk;
    cause.levelBad    = !levelOk;
    cause.densityBad  = densNext;
    cause.chanOff     = !chanEnable;
    cause.localForced = !useLocalClk;
    cause.refMissing  = !refClkPresent;
  end

  always_comb begin
    if (detEnable) detectorBad = cause.rateBad | cause.levelBad | cause.densityBad;
    else           detectorBad = cause.rateBad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      densFault  <= 1'b1;
      lockToRef  <= 1'b1;
      linkFaultN <= 1'b0;
    end else begin
      densFault  <= densNext;
      lockToRef  <= cause.localForced | detectorBad;
      linkFaultN <= ~(|cause);
    end
  end

  AST_LOCAL_FORCES_REF: assert property (@(posedge clk) disable iff (rst)
    !useLocalClk |=> (lockToRef && !linkFaultN));                 // R7
  AST_RANGE_FORCES_REF: assert property (@(posedge clk) disable iff (rst)
    !rangeOk |=> lockToRef);                                      // R5
  AST_LEVEL_GATES_LOCK: assert property (@(posedge clk) disable iff (rst)
    (detEnable && useLocalClk && !levelOk) |=> lockToRef);        // R5
  AST_RANGE_ONLY_MODE: assert property (@(posedge clk) disable iff (rst)
    (!detEnable && useLocalClk && rangeOk) |=> !lockToRef);       // R6
  AST_CLEAN_LINK_TRACKS: assert property (@(posedge clk) disable iff (rst)
    linkFaultN |-> !lockToRef);                                   // R8
  AST_EDGE_CLEARS_DENSITY: assert property (@(posedge clk) disable iff (rst)
    strobe.sawEdge |=> !densFault);                               // R3

endmodule

// File: rtl/rx_link_supervisor.sv
module rx_link_supervisor
  import rxsup_pkg::*;
#(
  parameter int RUN_LIMIT = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic bitIn,
  input  logic bitValid,
  input  logic rangeOk,
  input  logic levelOk,
  input  logic chanEnable,
  input  logic refClkPresent,
  input  logic useLocalClk,
  input  logic detEnable,
  output logic lockToRef,
  output logic linkFaultN
);

  runStrobe_t runStrobe;

  rxsup_run_counter #(.RUN_LIMIT(RUN_LIMIT)) u_run (
    .clk      (clk),
    .rst      (rst),
    .bitIn    (bitIn),
    .bitValid (bitValid),
    .strobe   (runStrobe)
  );

  rxsup_decide u_decide (
    .clk           (clk),
    .rst           (rst),
    .strobe        (runStrobe),
    .rangeOk       (rangeOk),
    .levelOk       (levelOk),
    .chanEnable    (chanEnable),
    .refClkPresent (refClkPresent),
    .useLocalClk   (useLocalClk),
    .detEnable     (detEnable),
    .lockToRef     (lockToRef),
    .linkFaultN    (linkFaultN)
  );

endmodule

// File: tb/rx_link_supervisor_bench.sv
`timescale 1ns/1ps
module rx_link_supervisor_bench;

  localparam int LIMIT = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitIn = 1'b0, bitValid = 1'b0;
  logic rangeOk = 1'b1, levelOk = 1'b1, chanEnable = 1'b1;
  logic refClkPresent = 1'b1, useLocalClk = 1'b1, detEnable = 1'b1;
  logic lockToRef, linkFaultN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_link_supervisor #(.RUN_LIMIT(LIMIT)) u_rx_link_supervisor (
    .clk(clk), .rst(rst), .bitIn(bitIn), .bitValid(bitValid),
    .rangeOk(rangeOk), .levelOk(levelOk), .chanEnable(chanEnable),
    .refClkPresent(refClkPresent), .useLocalClk(useLocalClk),
    .detEnable(detEnable), .lockToRef(lockToRef), .linkFaultN(linkFaultN)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expectOut(string req, logic expRef, logic expFaultN);
    checks++;
    if (lockToRef !== expRef || linkFaultN !== expFaultN) begin
      errors++;
      $display("FAIL %s: lockToRef=%b linkFaultN=%b expected %b %b",
               req, lockToRef, linkFaultN, expRef, expFaultN);
    end
  endtask

  task automatic sendBits(logic val, int n);
    for (int i = 0; i < n; i++) begin
      bitIn = val;
      bitValid = 1'b1;
      tick();
    end
    bitValid = 1'b0;
  endtask

  task automatic testReset();
    rst = 1'b1;
    tick(); tick();
    expectOut("R1 in reset", 1'b1, 1'b0);
    rst = 1'b0;
    tick(); tick(); tick();
    expectOut("R1 density fault held after reset", 1'b1, 1'b0);
  endtask

  task automatic testFirstEdge();
    sendBits(1'b0, 1);
    expectOut("R3 first bit has no predecessor", 1'b1, 1'b0);
    sendBits(1'b1, 1);
    expectOut("R3 level change clears density fault", 1'b0, 1'b1);
  endtask

  task automatic testRunLimit();
    // The last bit sent was 1, so the run count is 0
    sendBits(1'b1, LIMIT - 1);
    expectOut("R2 one short of limit stays clear", 1'b0, 1'b1);
    sendBits(1'b1, 1);
    expectOut("R2 limit reached sets density fault", 1'b1, 1'b0);
    sendBits(1'b1, 100);
    expectOut("R2 saturated run keeps fault", 1'b1, 1'b0);
    sendBits(1'b0, 1);
    expectOut("R3 change after saturation clears", 1'b0, 1'b1);
  endtask

  task automatic testValidGaps();
    // The last bit sent was 0, so the run count is 0
    sendBits(1'b0, LIMIT - 1);
    bitValid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      bitIn = i[0];
      tick();
    end
    expectOut("R4 unqualified bits ignored", 1'b0, 1'b1);
    sendBits(1'b0, 1);
    expectOut("R4 count kept across gap", 1'b1, 1'b0);
    sendBits(1'b1, 1);
    expectOut("R3 clear after gap test", 1'b0, 1'b1);
  endtask

  task automatic testFullGating();
    detEnable = 1'b1;
    levelOk = 1'b0;
    expectOut("R9 no change before edge", 1'b0, 1'b1);
    tick();
    expectOut("R5 amplitude low selects ref", 1'b1, 1'b0);
    levelOk = 1'b1;
    tick();
    expectOut("R9 recovery one edge later", 1'b0, 1'b1);
    rangeOk = 1'b0;
    tick();
    expectOut("R5 range bad selects ref", 1'b1, 1'b0);
    rangeOk = 1'b1;
    tick();
    // Same-edge case: trip the density fault, then clear it while amplitude drops
    sendBits(1'b1, LIMIT);
    expectOut("R5 density fault selects ref", 1'b1, 1'b0);
    levelOk = 1'b0;
    sendBits(1'b0, 1);
    expectOut("R5 shared edge: amplitude holds ref", 1'b1, 1'b0);
    levelOk = 1'b1;
    tick();
    expectOut("R3 shared edge cleared density", 1'b0, 1'b1);
  endtask

  task automatic testRangeOnly();
    detEnable = 1'b0;
    levelOk = 1'b0;
    tick();
    expectOut("R6 amplitude ignored for lock; R8 fault shown", 1'b0, 1'b0);
    levelOk = 1'b1;
    sendBits(1'b0, LIMIT);
    expectOut("R6 density ignored for lock; R8 fault shown", 1'b0, 1'b0);
    rangeOk = 1'b0;
    tick();
    expectOut("R6 range decides lock", 1'b1, 1'b0);
    rangeOk = 1'b1;
    sendBits(1'b1, 1);
    expectOut("R8 all causes clear in range-only mode", 1'b0, 1'b1);
    detEnable = 1'b1;
    tick();
  endtask

  task automatic testLocalAndOthers();
    useLocalClk = 1'b0;
    tick();
    expectOut("R7 local clock forces ref and fault", 1'b1, 1'b0);
    detEnable = 1'b0;
    tick();
    expectOut("R7 local clock force in range-only mode", 1'b1, 1'b0);
    useLocalClk = 1'b1;
    detEnable = 1'b1;
    tick();
    expectOut("R7 release", 1'b0, 1'b1);
    chanEnable = 1'b0;
    tick();
    expectOut("R8 channel disabled faults only", 1'b0, 1'b0);
    chanEnable = 1'b1;
    refClkPresent = 1'b0;
    tick();
    expectOut("R8 reference missing faults only", 1'b0, 1'b0);
    refClkPresent = 1'b1;
    tick();
    expectOut("R8 all clear", 1'b0, 1'b1);
  endtask

  initial begin
    testReset();
    testFirstEdge();
    testRunLimit();
    testValidGaps();
    testFullGating();
    testRangeOnly();
    testLocalAndOthers();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule